// File: doc/BRIEF.md
# Static LCD Backplane and Segment Phase Generator

This block produces the backplane square wave for a static (one backplane, non-multiplexed) seven-segment LCD and drives each segment pin either in phase with the backplane or against it. A segment that is driven in phase shows no voltage across the glass and stays dark. A segment that is driven against the phase sees a symmetric AC swing with no DC component and is visible. The system clock is qualified by an oscillator tick enable, and that tick feeds a divide-by-128 chain. Each backplane period lasts 128 ticks: 64 ticks low, then 64 ticks high.

In master mode the block drives the backplane itself. In slave mode it releases the backplane pin and takes the segment phase from the external backplane level, after a two-flop synchronizer. Several instances can therefore share one backplane. A low level on the sense input requests slave mode. The block grants that request only after the level has stayed low for `MIN_LOW_TICKS` consecutive clocks, so short low pulses are rejected. At the default of 100 clocks and a 100 MHz clock this is about one microsecond.

Top module: `lcd_bp_phase_gen`

## Requirements
- R1: While `rst_ni` is low, `bp_o` is 0, `bp_oe_o` is 1 and every bit of `seg_o` is 0, whatever the value of `seg_on_i`.
- R2: In master mode, `bp_o` is low for the first 64 ticks after reset or after leaving slave mode, and high for the next 64, repeating every 128 ticks. A tick is a clock with `osc_tick_i` high. `bp_o` updates on the second clock edge after the tick that changes it.
- R3: The divider advances only on clocks where `osc_tick_i` is 1. Any number of clocks without a tick leaves `bp_o` and `seg_o` unchanged.
- R4: `seg_o[i]` equals the current phase XOR `seg_on_i[i]`, one clock after `seg_on_i` changes. A 1 in `seg_on_i[i]` means the segment is lit. The phase is the master backplane level in master mode and the synchronized `bp_ext_i` in slave mode.
- R5: `osc_sense_i` held at 0 for `MIN_LOW_TICKS` consecutive clocks enters slave mode on the clock edge that samples the last of them. `bp_oe_o` drops to 0 on that edge and not earlier.
- R6: A low run on `osc_sense_i` shorter than `MIN_LOW_TICKS` clocks has no effect: `bp_oe_o` stays 1 and the backplane phase continues undisturbed.
- R7: Slave mode is left on the first clock edge that samples `osc_sense_i` as 1, and `bp_oe_o` returns to 1 on that edge.
- R8: In slave mode, a change on `bp_ext_i` reaches `seg_o` on the third clock edge after it is applied, through two synchronizer stages and the segment register.
- R9: In slave mode the divider is held at zero and `bp_o` is 0 from the second slave clock onward. After slave mode ends, the master backplane restarts at the start of its low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | One-clock oscillator tick enable for the divider |
| osc_sense_i | input | 1 | Oscillator sense level; a sustained 0 requests slave mode |
| bp_ext_i | input | 1 | Backplane pin level read as an input (used in slave mode) |
| seg_on_i | input | 28 | Per-segment lit request, 7 per digit, 4 digits |
| bp_o | output | 1 | Backplane value driven in master mode |
| bp_oe_o | output | 1 | Backplane output enable, 0 in slave mode |
| seg_o | output | 28 | Segment pin values |

## Verification
A divider that has slipped or been cleared by mistake shows up as `bp_o` flipping at the wrong tick count. This is visible within one half-period, 64 ticks at most. A filter that counts wrongly or does not restart its count moves the fall of `bp_oe_o` off the exact clock on which it should occur. The bench therefore samples the clock just before that edge and the edge itself. A synchronizer with the wrong depth moves the segment flip away from the third edge after `bp_ext_i` changes. A polarity or bit-order slip in the segment XOR shows on the first pattern that pairs a lit segment with either backplane level.

// File: rtl/lcd_bp_pkg.sv
package lcd_bp_pkg;
  typedef enum logic {
    MODE_MASTER = 1'b0,
    MODE_SLAVE  = 1'b1
  } bp_mode_e;
endpackage

// File: rtl/bp_mode_filter.sv
module bp_mode_filter
  import lcd_bp_pkg::*;
#(
  parameter int unsigned MIN_LOW_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sense_i,
  output logic slave_o
);
  localparam int unsigned CNT_W = $clog2(MIN_LOW_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_LOW_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_LOW_TICKS - 1);

  logic [CNT_W-1:0] low_cnt_q;
  bp_mode_e         mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      mode_q    <= MODE_MASTER;
    end else if (sense_i) begin
      low_cnt_q <= '0;
      mode_q    <= MODE_MASTER;
    end else begin
      if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
      if (low_cnt_q >= CNT_LAST) mode_q <= MODE_SLAVE;
    end
  end

  assign slave_o = (mode_q == MODE_SLAVE);

  AST_HIGH_EXITS_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_i |=> !slave_o); // R7
  AST_ENTRY_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slave_o) |-> $past(!sense_i)); // R6
endmodule

// File: rtl/bp_divider.sv
module bp_divider #(
  parameter int unsigned DIV_LOG2 = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  output logic phase_o
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // upper half of the count is the high backplane half
  assign phase_o = cnt_q[DIV_LOG2-1];

  AST_HOLD_CLEARS_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0)); // R9
  AST_NO_TICK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !hold_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/bp_sync2.sv
module bp_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], d_i};
  end

  assign q_o = sync_q[1];
endmodule

// File: rtl/seg_phase_drv.sv
module seg_phase_drv #(
  parameter int unsigned NUM_SEG = 28
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_i,
  input  logic [NUM_SEG-1:0] on_i,
  output logic [NUM_SEG-1:0] seg_o
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic seg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seg_q <= 1'b0;
      else         seg_q <= phase_i ^ on_i[g];
    end
    assign seg_o[g] = seg_q;
  end
endmodule

// File: rtl/lcd_bp_phase_gen.sv
module lcd_bp_phase_gen #(
  parameter int unsigned NUM_DIGITS    = 4,
  parameter int unsigned SEG_PER_DIGIT = 7,
  parameter int unsigned DIV_LOG2      = 7,
  parameter int unsigned MIN_LOW_TICKS = 100,
  localparam int unsigned NUM_SEG      = NUM_DIGITS * SEG_PER_DIGIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_tick_i,
  input  logic               osc_sense_i,
  input  logic               bp_ext_i,
  input  logic [NUM_SEG-1:0] seg_on_i,
  output logic               bp_o,
  output logic               bp_oe_o,
  output logic [NUM_SEG-1:0] seg_o
);
  logic slave;
  logic master_phase;
  logic ext_phase;
  logic phase;
  logic bp_q;

  bp_mode_filter #(.MIN_LOW_TICKS(MIN_LOW_TICKS)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sense_i (osc_sense_i),
    .slave_o (slave)
  );

  bp_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (osc_tick_i),
    .hold_i  (slave),
    .phase_o (master_phase)
  );

  bp_sync2 u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bp_ext_i),
    .q_o    (ext_phase)
  );

  assign phase = slave ? ext_phase : master_phase;

  seg_phase_drv #(.NUM_SEG(NUM_SEG)) u_seg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .on_i    (seg_on_i),
    .seg_o   (seg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bp_q <= 1'b0;
    else         bp_q <= slave ? 1'b0 : master_phase;
  end

  assign bp_o    = bp_q;
  assign bp_oe_o = !slave;

  AST_SLAVE_BP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bp_oe_o && $past(!bp_oe_o)) |-> !bp_o); // R9
  AST_MASTER_SEG_TRACKS_BP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_oe_o && $past(bp_oe_o) && $stable(seg_on_i) && $stable(bp_o))
      |=> (seg_o == ({NUM_SEG{bp_o}} ^ $past(seg_on_i)))); // R4
endmodule

// File: tb/lcd_bp_phase_gen_tb.sv
module lcd_bp_phase_gen_tb_top;
  localparam int unsigned MIN_LOW = 100;
  localparam int unsigned NV = 8;
  localparam int unsigned VEC_TICKS [NV] = '{10, 54, 63, 1, 64, 30, 100, 20};
  localparam logic [27:0] VEC_PAT [NV] = '{28'h0000000, 28'hFFFFFFF, 28'h5A5A5A5,
    28'h0000001, 28'h8000000, 28'h1234567, 28'hA5A5A5A, 28'h7F00FE1};

  logic clk = 0, rst_n = 0, tick = 0, sense = 1, ext = 0;
  logic [27:0] on = '1;
  logic bp, oe;
  logic [27:0] seg;
  int n_chk = 0, n_fail = 0;
  int total = 0;

  always #5 clk = ~clk;

  lcd_bp_phase_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .osc_sense_i(sense),
    .bp_ext_i(ext), .seg_on_i(on), .bp_o(bp), .bp_oe_o(oe), .seg_o(seg));

  task automatic chk(string req, logic [27:0] act, logic [27:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1;
      @(negedge clk);
    end
    tick = 0;
    total += n;
    cyc(2);
  endtask

  function automatic logic exp_bp();
    return (total % 128) >= 64;
  endfunction

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 bp", 28'(bp), 28'(0));
    chk("R1 oe", 28'(oe), 28'(1));
    chk("R1 seg", seg, 28'h0);
    @(negedge clk); rst_n = 1; on = '0;
    cyc(2);

    // master mode vector walk
    for (int v = 0; v < NV; v++) begin
      on = VEC_PAT[v];
      ticks(VEC_TICKS[v]);
      chk("R2 bp", 28'(bp), 28'(exp_bp()));
      chk("R4 seg", seg, VEC_PAT[v] ^ {28{exp_bp()}});
    end

    // R3: many clocks without tick
    cyc(200);
    chk("R3 bp idle", 28'(bp), 28'(exp_bp()));
    chk("R3 seg idle", seg, on ^ {28{exp_bp()}});

    // R4: pattern change reaches seg after one edge
    on = 28'h0F0F0F0;
    cyc(1);
    chk("R4 seg one edge", seg, 28'h0F0F0F0 ^ {28{exp_bp()}});

    // R6: low run one short of the limit
    sense = 0;
    cyc(MIN_LOW - 1);
    chk("R6 oe during glitch", 28'(oe), 28'(1));
    sense = 1;
    cyc(2);
    chk("R6 oe after glitch", 28'(oe), 28'(1));
    chk("R6 bp kept", 28'(bp), 28'(exp_bp()));
    ticks(1);
    chk("R6 phase continues", 28'(bp), 28'(exp_bp()));

    // R5: entry exactly at the limit
    on = 28'h3C3C3C3;
    sense = 0;
    cyc(MIN_LOW - 1);
    chk("R5 oe one before", 28'(oe), 28'(1));
    cyc(1);
    chk("R5 oe at limit", 28'(oe), 28'(0));
    cyc(2);
    chk("R9 bp low slave", 28'(bp), 28'(0));
    chk("R8 seg ext low", seg, 28'h3C3C3C3);

    // R8: sync latency
    ext = 1;
    cyc(2);
    chk("R8 seg after two", seg, 28'h3C3C3C3);
    cyc(1);
    chk("R8 seg after three", seg, ~28'h3C3C3C3);
    ticks(20);
    chk("R9 bp low with ticks", 28'(bp), 28'(0));
    chk("R8 seg held ext", seg, ~28'h3C3C3C3);
    ext = 0;
    cyc(3);
    chk("R8 seg ext fall", seg, 28'h3C3C3C3);

    // R7: exit on first high
    sense = 1;
    cyc(1);
    chk("R7 oe exit", 28'(oe), 28'(1));
    total = 0;
    ticks(63);
    chk("R9 restart low", 28'(bp), 28'(0));
    chk("R9 seg low half", seg, 28'h3C3C3C3);
    ticks(1);
    chk("R9 restart high", 28'(bp), 28'(1));
    chk("R2 seg high half", seg, ~28'h3C3C3C3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule